// File: doc/BRIEF.md
# Microprogrammed Two-Bank Register Datapath

This block is a tiny microprogrammed datapath. It holds eight 8-bit registers in two banks of four, called Y and Z. On each step one register from Y and one from Z feed a shared ALU, and the result goes back into exactly one of the eight registers. The sequence of operations is fixed in an internal read-only control store of sixteen 9-bit horizontal micro-words. A 4-bit program counter addresses the control store and advances by one on every enabled cycle, wrapping from the last word back to the first.

The block has no branching, no data inputs and no external memory. At reset every register is loaded with a fixed seed value, so the fixed program computes a known sequence of values. While `run` is high the datapath executes one micro-word per clock. While `run` is low it freezes. All eight registers and the program counter are visible on debug outputs, so a test or a neighbouring block can follow each step.

Top module: `ucode_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the program counter to 0 and loads register k of bank Y with SEED+k and register k of bank Z with SEED+4+k (default SEED=1, so Y0..Y3 = 1..4 and Z0..Z3 = 5..8). No write from the ALU happens on that edge.
- R2: On each rising edge with `rst` low and `run` high, the program counter increases by one, wrapping from 15 to 0.
- R3: On a rising edge with `rst` low and `run` low, the program counter and all eight registers keep their values.
- R4: ALU code 00 writes Y[ysel] + Z[zsel], truncated to 8 bits.
- R5: ALU code 01 writes Y[ysel] - Z[zsel], taken modulo 256.
- R6: ALU code 10 writes the bitwise AND of Y[ysel] and Z[zsel].
- R7: ALU code 11 writes the bitwise OR of Y[ysel] and Z[zsel].
- R8: Destination codes 0 to 3 select Y0 to Y3 and codes 4 to 7 select Z0 to Z3. On an enabled step only the destination register changes; the other seven hold their values.
- R9: The micro-word at the current program counter value controls the step. Bits [8:7] are the ALU code, bits [6:5] the Y read select, bits [4:3] the Z read select and bits [2:0] the destination. The store holds a fixed 16-word program that includes every ALU code and every destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Step enable; when low the datapath holds |
| y_view | output | 4*W | Bank Y contents, register k in bits [k*W +: W] |
| z_view | output | 4*W | Bank Z contents, register k in bits [k*W +: W] |
| pc_view | output | 4 | Current program counter |

## Verification
Every effect of a step, whether a register write, a counter advance or a reset load, appears on the debug outputs one rising edge after the driver applies `run` or `rst` at a falling edge. A micro-word's result is therefore due exactly one edge after the program counter points at it. The driver updates a reference model at the falling edge and queues the predicted state. The monitor takes one item off the queue 1 ns after each rising edge and compares it with the outputs, so each prediction is matched against the cycle in which it must appear.

// File: rtl/ucode_datapath.sv
module ucode_datapath #(
  parameter int W    = 8,
  parameter int SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  output logic [4*W-1:0] y_view,
  output logic [4*W-1:0] z_view,
  output logic [3:0]   pc_view
);
  localparam int NREG = 4;

  logic [W-1:0] ybank [NREG];
  logic [W-1:0] zbank [NREG];
  logic [3:0]   pc;
  logic [8:0]   uword;
  logic [1:0]   op, ysel, zsel;
  logic [2:0]   dst;
  logic [W-1:0] opa, opb, res;

  always_comb begin
    case (pc)
      4'd0:  uword = {2'd0, 2'd0, 2'd0, 3'd0};
      4'd1:  uword = {2'd1, 2'd1, 2'd3, 3'd5};
      4'd2:  uword = {2'd2, 2'd2, 2'd1, 3'd3};
      4'd3:  uword = {2'd3, 2'd3, 2'd2, 3'd4};
      4'd4:  uword = {2'd0, 2'd3, 2'd3, 3'd7};
      4'd5:  uword = {2'd1, 2'd0, 2'd0, 3'd1};
      4'd6:  uword = {2'd3, 2'd1, 2'd1, 3'd2};
      4'd7:  uword = {2'd2, 2'd0, 2'd3, 3'd6};
      4'd8:  uword = {2'd0, 2'd2, 2'd2, 3'd0};
      4'd9:  uword = {2'd1, 2'd3, 2'd0, 3'd7};
      4'd10: uword = {2'd3, 2'd0, 2'd2, 3'd5};
      4'd11: uword = {2'd2, 2'd1, 2'd0, 3'd4};
      4'd12: uword = {2'd1, 2'd2, 2'd3, 3'd3};
      4'd13: uword = {2'd0, 2'd1, 2'd1, 3'd6};
      4'd14: uword = {2'd3, 2'd2, 2'd3, 3'd1};
      default: uword = {2'd1, 2'd0, 2'd1, 3'd2};
    endcase
  end

  assign {op, ysel, zsel, dst} = uword;
  assign opa = ybank[ysel];
  assign opb = zbank[zsel];

  always_comb begin
    case (op)
      2'd0:    res = opa + opb;
      2'd1:    res = opa - opb;
      2'd2:    res = opa & opb;
      default: res = opa | opb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      for (int k = 0; k < NREG; k++) begin
        ybank[k] <= W'(SEED + k);
        zbank[k] <= W'(SEED + NREG + k);
      end
    end else if (run) begin
      pc <= pc + 4'd1;
      if (dst[2]) zbank[dst[1:0]] <= res;
      else        ybank[dst[1:0]] <= res;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign y_view[g*W +: W] = ybank[g];
    assign z_view[g*W +: W] = zbank[g];
  end
  assign pc_view = pc;
endmodule

module ucode_datapath_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           run,
  input logic [4*W-1:0] y_view,
  input logic [4*W-1:0] z_view,
  input logic [3:0]     pc_view
);
  logic [4*W-1:0] y_prev, z_prev;
  logic           prev_ok;
  logic [7:0]     chg;

  always_ff @(posedge clk) begin
    y_prev  <= y_view;
    z_prev  <= z_view;
    prev_ok <= !rst && run;
    if (rst) prev_ok <= 1'b0;
  end

  for (genvar g = 0; g < 4; g++) begin : g_chg
    assign chg[g]   = y_view[g*W +: W] != y_prev[g*W +: W];
    assign chg[g+4] = z_view[g*W +: W] != z_prev[g*W +: W];
  end

  a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc_view == 4'd0);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    run |=> pc_view == 4'($past(pc_view) + 4'd1));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pc_view) && $stable(y_view) && $stable(z_view));

  a_r8_one_dest: assert property (@(posedge clk) disable iff (rst)
    prev_ok |-> $onehot0(chg));
endmodule

bind ucode_datapath ucode_datapath_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .run(run),
  .y_view(y_view), .z_view(z_view), .pc_view(pc_view)
);

// File: tb/tb_ucode_datapath.sv
module tb_ucode_datapath;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [4*W-1:0] y_view, z_view;
  logic [3:0] pc_view;

  always #2 clk = ~clk;

  ucode_datapath #(.W(W), .SEED(1)) dut (
    .clk(clk), .rst(rst), .run(run),
    .y_view(y_view), .z_view(z_view), .pc_view(pc_view)
  );

  typedef struct packed {
    logic [1:0]     kind;   // 0 reset, 1 hold, 2 step
    logic [1:0]     op;
    logic [2:0]     dst;
    logic [3:0]     pc;
    logic [4*W-1:0] y;
    logic [4*W-1:0] z;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic [W-1:0] my [4];
  logic [W-1:0] mz [4];
  logic [3:0]   mpc;

  // R9: fixed program, fields {alu[8:7], ysel[6:5], zsel[4:3], dst[2:0]}
  function automatic logic [8:0] prog(input logic [3:0] p);
    case (p)
      4'd0:  return {2'd0, 2'd0, 2'd0, 3'd0};
      4'd1:  return {2'd1, 2'd1, 2'd3, 3'd5};
      4'd2:  return {2'd2, 2'd2, 2'd1, 3'd3};
      4'd3:  return {2'd3, 2'd3, 2'd2, 3'd4};
      4'd4:  return {2'd0, 2'd3, 2'd3, 3'd7};
      4'd5:  return {2'd1, 2'd0, 2'd0, 3'd1};
      4'd6:  return {2'd3, 2'd1, 2'd1, 3'd2};
      4'd7:  return {2'd2, 2'd0, 2'd3, 3'd6};
      4'd8:  return {2'd0, 2'd2, 2'd2, 3'd0};
      4'd9:  return {2'd1, 2'd3, 2'd0, 3'd7};
      4'd10: return {2'd3, 2'd0, 2'd2, 3'd5};
      4'd11: return {2'd2, 2'd1, 2'd0, 3'd4};
      4'd12: return {2'd1, 2'd2, 2'd3, 3'd3};
      4'd13: return {2'd0, 2'd1, 2'd1, 3'd6};
      4'd14: return {2'd3, 2'd2, 2'd3, 3'd1};
      default: return {2'd1, 2'd0, 2'd1, 3'd2};
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'd0: return "R4/R9";
      2'd1: return "R5/R9";
      2'd2: return "R6/R9";
      default: return "R7/R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic go);
    item_t it;
    logic [8:0] w;
    logic [W-1:0] a, b, res;
    @(negedge clk);
    rst = r;
    run = go;
    w = prog(mpc);
    it.op = w[8:7];
    it.dst = w[2:0];
    if (r) begin
      it.kind = 2'd0;
      mpc = 4'd0;
      for (int k = 0; k < 4; k++) begin
        my[k] = W'(1 + k);
        mz[k] = W'(5 + k);
      end
    end else if (go) begin
      it.kind = 2'd2;
      a = my[w[6:5]];
      b = mz[w[4:3]];
      case (w[8:7])
        2'd0: res = a + b;
        2'd1: res = a - b;
        2'd2: res = a & b;
        default: res = a | b;
      endcase
      if (w[2]) mz[w[1:0]] = res;
      else      my[w[1:0]] = res;
      mpc = mpc + 4'd1;
    end else begin
      it.kind = 2'd1;
    end
    it.pc = mpc;
    for (int k = 0; k < 4; k++) begin
      it.y[k*W +: W] = my[k];
      it.z[k*W +: W] = mz[k];
    end
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      string pt, rt;
      it = q.pop_front();
      pt = (it.kind == 2'd0) ? "R1" : (it.kind == 2'd2) ? "R2" : "R3";
      check(pt, "pc", W'(pc_view), W'(it.pc));
      for (int k = 0; k < 8; k++) begin
        if (it.kind != 2'd2) rt = pt;
        else if (3'(k) == it.dst) rt = op_tag(it.op);
        else rt = "R8";
        if (k < 4) check(rt, $sformatf("Y%0d", k), y_view[k*W +: W], it.y[k*W +: W]);
        else       check(rt, $sformatf("Z%0d", k-4), z_view[(k-4)*W +: W], it.z[(k-4)*W +: W]);
      end
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      my[k] = '0;
      mz[k] = '0;
    end
    mpc = '0;
    step(1'b1, 1'b0);                            // R1 reset load
    step(1'b1, 1'b1);                            // R1 reset wins over run
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1); // R2 wrap, R4..R9
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);  // R3 hold
    for (int i = 0; i < 14; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);                            // R1 mid-run reset
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    run = 1'b0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule